// File: doc/BRIEF.md
# Memory-Mapped Seconds Real-Time Clock

This block is a real-time-clock slave on a plain 32-bit register bus. A free-running seconds count advances by one on every clock cycle in which the tick-enable input is high. That input is normally a one-pulse-per-second strobe from a prescaler outside the block. Software reads the count directly. It can also read a relative counter that restarts from zero whenever any word is written to it. A programmable match value raises a level interrupt when the seconds count steps onto it.

A single offset serves two purposes. A read returns the interrupt flag. A write either clears the flag (data zero) or forces it set (any nonzero data), which lets software raise the interrupt on purpose. Two fixed identification words sit near the top of a 4 KiB window. Every access completes in the cycle it is presented. Read data is captured at that clock edge and holds until the next accepted word read. Only full-word accesses have any effect.

Top module: `secrtc_top`

## Requirements
- R1: After reset is released, `irq` is 0, `bus_rdata` is 0, the seconds count and the match value read 0, and the relative counter (offset 0x10) reads 0.
- R2: The seconds count increments by one on each clock edge where `tick_en` is 1 and holds otherwise. A word read at offset 0x00 returns it. Writes to 0x00 change nothing.
- R3: Offset 0x04 is a read/write match register. A word read returns the last word written there, and reads do not disturb it.
- R4: A word write to 0x08 with data 0 clears the interrupt flag. A word write to 0x08 with nonzero data sets it. `irq` equals the flag.
- R5: A word read of 0x08 returns the flag in bit 0 and zeros in bits 31..1.
- R6: A word write of any data to 0x10 captures the seconds count as it stands after that edge. A word read of 0x10 returns the seconds count minus that captured value, modulo 2^32.
- R7: When a `tick_en` edge advances the seconds count to a value equal to the match register, the flag is set. This set takes priority over a clearing write to 0x08 in the same cycle.
- R8: A word read of offset 0xFE0 returns 0x00041030. A word read of 0xFD8 returns 0x000FFFFF.
- R9: An access whose `bus_size` is not 2 (2 = 32-bit word; 0 = byte, 1 = halfword, 3 = reserved) is ignored. A write changes no register and a read leaves `bus_rdata` unchanged.
- R10: A word read of the load offset 0x0C, or of any unmapped offset, returns 0. Writes to these offsets change no state.
- R11: `bus_rdata` updates only on the clock edge of an accepted word read, and it then holds its value through idle cycles and all other accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Seconds advance strobe, one cycle per second |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level-high alarm interrupt |

## Verification
The seconds count is driven by isolated tick pulses, by a tick that coincides with a bus write, and by long stretches without ticks. This separates counting on the strobe from counting on every clock. The interrupt flag is reached through a software set, a match event, and a match event that lands in the same cycle as a clearing write, so the priority of the two sources is tested. The relative counter is rebased in a cycle that also carries a tick, which shows whether the captured base is the old count or the new one. Sub-word and unmapped accesses come between reads of known values, so any leak into state or into the read data shows up.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Register byte offsets (software-visible contract)
  localparam int unsigned OFS_SECONDS = 'h000;
  localparam int unsigned OFS_ALARM   = 'h004;
  localparam int unsigned OFS_FLAG    = 'h008;
  localparam int unsigned OFS_PRESET  = 'h00C;
  localparam int unsigned OFS_ELAPSED = 'h010;

  // Distance of identification words below the top of the window
  localparam int unsigned IDENT_BACKOFF = 'h20;
  localparam int unsigned MASKW_BACKOFF = 'h28;

  localparam logic [31:0] IDENT_WORD = 32'h0004_1030;
  localparam logic [31:0] MASK_WORD  = 32'h000F_FFFF;

  typedef struct packed {
    logic seconds;
    logic alarm;
    logic flag;
    logic preset;
    logic elapsed;
    logic ident;
    logic maskw;
  } reg_hit_t;

endpackage

// File: rtl/secrtc_decode.sv
module secrtc_decode
  import secrtc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  output reg_hit_t          hit,
  output logic              wr_fire,
  output logic              rd_fire
);

  localparam int unsigned WIN_BYTES = 1 << ADDR_W;
  localparam int unsigned NREG      = 7;
  localparam int unsigned OFS_IDENT = WIN_BYTES - IDENT_BACKOFF;
  localparam int unsigned OFS_MASKW = WIN_BYTES - MASKW_BACKOFF;

  localparam int unsigned OFS_TAB [NREG] = '{
    OFS_SECONDS, OFS_ALARM, OFS_FLAG, OFS_PRESET, OFS_ELAPSED,
    OFS_IDENT, OFS_MASKW
  };

  logic              word_ok;
  logic [NREG-1:0]   match_vec;

  assign word_ok = bus_sel && (acc_size_e'(bus_size) == SZ_WORD);
  assign wr_fire = word_ok && bus_wr;
  assign rd_fire = word_ok && !bus_wr;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign match_vec[g] = (bus_addr == ADDR_W'(OFS_TAB[g]));
  end

  always_comb begin
    hit.seconds = match_vec[0];
    hit.alarm   = match_vec[1];
    hit.flag    = match_vec[2];
    hit.preset  = match_vec[3];
    hit.elapsed = match_vec[4];
    hit.ident   = match_vec[5];
    hit.maskw   = match_vec[6];
  end

endmodule

// File: rtl/secrtc_count.sv
module secrtc_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             rebase,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] sec_q,
  output logic [CNT_W-1:0] elapsed,
  output logic             alarm_hit
);

  logic [CNT_W-1:0] sec_d;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] base_d;

  always_comb begin
    sec_d  = sec_q + CNT_W'(1);
    base_d = tick_en ? sec_d : sec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (tick_en) begin
      sec_q <= sec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (rebase) begin
      base_q <= base_d;
    end
  end

  assign elapsed   = sec_q - base_q;
  assign alarm_hit = tick_en && (sec_d == alarm_val);

endmodule

// File: rtl/secrtc_irq.sv
module secrtc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_hit,
  input  logic sw_wr,
  input  logic sw_nonzero,
  output logic flag_q
);

  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = alarm_hit || sw_wr;
    flag_d  = alarm_hit ? 1'b1 : sw_nonzero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/secrtc_top.sv
module secrtc_top
  import secrtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  reg_hit_t          hit;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] sec_now;
  logic [DATA_W-1:0] elapsed;
  logic [DATA_W-1:0] match_now;
  logic [DATA_W-1:0] match_d;
  logic              match_en;
  logic              alarm_hit;
  logic              flag_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  secrtc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .hit      (hit),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire)
  );

  secrtc_count #(.CNT_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .rebase    (wr_fire && hit.elapsed),
    .alarm_val (match_now),
    .sec_q     (sec_now),
    .elapsed   (elapsed),
    .alarm_hit (alarm_hit)
  );

  secrtc_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm_hit  (alarm_hit),
    .sw_wr      (wr_fire && hit.flag),
    .sw_nonzero (|bus_wdata),
    .flag_q     (flag_q)
  );

  // Alarm compare value
  always_comb begin
    match_en = wr_fire && hit.alarm;
    match_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_now <= '0;
    end else if (match_en) begin
      match_now <= match_d;
    end
  end

  // Read-back selection; preset and unmapped offsets return zero
  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit.seconds: rd_mux = sec_now;
      hit.alarm:   rd_mux = match_now;
      hit.flag:    rd_mux = DATA_W'(flag_q);
      hit.elapsed: rd_mux = elapsed;
      hit.ident:   rd_mux = DATA_W'(IDENT_WORD);
      hit.maskw:   rd_mux = DATA_W'(MASK_WORD);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_fire) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = flag_q;

endmodule

// File: rtl/secrtc_chk.sv
module secrtc_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] sec_now,
  input logic [DATA_W-1:0] match_now
);

  logic word_wr;
  logic word_rd;
  logic step_hit;

  assign word_wr  = bus_sel && bus_wr && (bus_size == 2'd2);
  assign word_rd  = bus_sel && !bus_wr && (bus_size == 2'd2);
  assign step_hit = tick_en && ((sec_now + DATA_W'(1)) == match_now);

  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> sec_now == $past(sec_now) + DATA_W'(1));

  p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(sec_now));

  p_alarm_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && bus_addr == ADDR_W'('h004)) |=> match_now == $past(bus_wdata));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && bus_addr == ADDR_W'('h008) && bus_wdata != '0) |=> irq);

  p_flag_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && bus_addr == ADDR_W'('h008) && bus_wdata == '0 && !step_hit) |=> !irq);

  p_flag_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd && bus_addr == ADDR_W'('h008)) |=> bus_rdata == DATA_W'($past(irq)));

  p_alarm_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_hit |=> irq);

  p_subword_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != 2'd2) |=> ($stable(match_now) && $stable(bus_rdata)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !word_rd |=> $stable(bus_rdata));

endmodule

bind secrtc_top secrtc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .sec_now   (sec_now),
  .match_now (match_now)
);

// File: tb/sim_secrtc_top.sv
`timescale 1ns/1ps
module sim_secrtc_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int NVEC       = 15;

  logic              clk;
  logic              rst_n;
  logic              tick_en;
  logic              bus_sel;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;

  int n_cmp;
  int n_bad;
  bit done;

  secrtc_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector table: write flag, offset, size code, write data, expected read data
  localparam logic              V_WR   [NVEC] = '{1,0,1,0,1,0,0,0,0,0,1,0,1,0,0};
  localparam logic [ADDR_W-1:0] V_ADDR [NVEC] = '{
    'h004,'h004,'h000,'h000,'h004,'h004,'hFE0,'hFD8,'h00C,'h100,
    'h008,'h008,'h008,'h008,'h010};
  localparam logic [1:0]        V_SIZE [NVEC] = '{2,2,2,2,0,2,2,2,2,2,2,2,2,2,2};
  localparam logic [DATA_W-1:0] V_DATA [NVEC] = '{
    32'h5, 0, 32'hDEAD, 0, 32'h77, 0, 0, 0, 0, 0, 32'h3, 0, 0, 0, 0};
  localparam logic [DATA_W-1:0] V_EXP  [NVEC] = '{
    0, 32'h5, 0, 32'h0, 0, 32'h5, 32'h0004_1030, 32'h000F_FFFF, 32'h0, 32'h0,
    0, 32'h1, 0, 32'h0, 32'h0};
  localparam string V_TAG [NVEC] = '{
    "R3","R3","R2","R2","R9","R9","R8","R8","R10","R10",
    "R4","R5","R4","R5","R6"};

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_sel   = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_size  = 2'd2;
    bus_wdata = '0;
    tick_en   = 1'b0;
  endtask

  // One bus cycle; results sampled a quarter period after the edge
  task automatic access(input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [1:0] sz, input logic [DATA_W-1:0] d,
                        input logic tk);
    @(negedge clk);
    bus_sel   = 1'b1;
    bus_wr    = wr;
    bus_addr  = a;
    bus_size  = sz;
    bus_wdata = d;
    tick_en   = tk;
    @(posedge clk);
    #(CLK_PERIOD/4);
    idle_inputs();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(posedge clk);
      #(CLK_PERIOD/4);
      tick_en = 1'b0;
    end
  endtask

  task automatic rd_check(input string tag, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] exp);
    access(1'b0, a, 2'd2, '0, 1'b0);
    check(tag, bus_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    idle_inputs();
    do_reset();

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);

    // Table walk
    for (int k = 0; k < NVEC; k++) begin
      access(V_WR[k], V_ADDR[k], V_SIZE[k], V_DATA[k], 1'b0);
      if (!V_WR[k]) check(V_TAG[k], bus_rdata, V_EXP[k]);
    end

    // R2 counting on ticks, R6 elapsed with base 0 since reset
    ticks(3);
    rd_check("R2 count", 'h000, 32'd3);
    rd_check("R6 elapsed since reset", 'h010, 32'd3);

    // R7 match event: alarm = 5, count 3 -> 5
    ticks(1);
    check("R7 no early irq", {31'b0, irq}, 32'h0);
    ticks(1);
    check("R7 irq on match", {31'b0, irq}, 32'h1);
    rd_check("R5 flag read", 'h008, 32'h1);

    // R4 clear, then R7 priority of match over same-cycle clear
    access(1'b1, 'h008, 2'd2, 32'h0, 1'b0);
    check("R4 clear", {31'b0, irq}, 32'h0);
    access(1'b1, 'h004, 2'd2, 32'd6, 1'b0);
    access(1'b1, 'h008, 2'd2, 32'h0, 1'b1);
    check("R7 match beats clear", {31'b0, irq}, 32'h1);
    access(1'b1, 'h008, 2'd2, 32'h0, 1'b0);
    check("R4 clear again", {31'b0, irq}, 32'h0);

    // R6 rebase in a tick cycle: count 6 -> 7, base 7
    access(1'b1, 'h010, 2'd2, 32'hFFFF_FFFF, 1'b1);
    rd_check("R6 elapsed after rebase", 'h010, 32'd0);
    ticks(4);
    rd_check("R6 elapsed grows", 'h010, 32'd4);
    rd_check("R2 count after rebase", 'h000, 32'd11);

    // R9 sub-word read keeps data, sub-word writes ignored
    access(1'b0, 'h000, 2'd1, '0, 1'b0);
    check("R9 halfword read holds", bus_rdata, 32'd11);
    access(1'b1, 'h008, 2'd0, 32'h1, 1'b0);
    check("R9 byte write to flag", {31'b0, irq}, 32'h0);
    access(1'b1, 'h010, 2'd3, 32'h0, 1'b0);
    rd_check("R9 reserved-size write no rebase", 'h010, 32'd4);

    // R10 load offset and unmapped writes have no effect
    access(1'b1, 'h00C, 2'd2, 32'hABCD, 1'b0);
    access(1'b1, 'h200, 2'd2, 32'h1234, 1'b0);
    rd_check("R10 alarm untouched", 'h004, 32'd6);
    rd_check("R10 preset reads zero", 'h00C, 32'h0);
    rd_check("R10 misaligned reads zero", 'h002, 32'h0);

    // R11 read data holds across idle and write cycles
    rd_check("R8 ident", 'hFE0, 32'h0004_1030);
    repeat (3) @(negedge clk);
    check("R11 hold idle", bus_rdata, 32'h0004_1030);
    access(1'b1, 'h004, 2'd2, 32'd9, 1'b0);
    check("R11 hold on write", bus_rdata, 32'h0004_1030);

    // R1 reset mid-run
    access(1'b1, 'h008, 2'd2, 32'h1, 1'b0);
    do_reset();
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd_check("R1 alarm after reset", 'h004, 32'h0);
    rd_check("R1 count after reset", 'h000, 32'h0);
    rd_check("R1 elapsed after reset", 'h010, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule